// File: doc/BRIEF.md
# Video Sync Rate Meter

This block measures the field rate and the line rate of one of three sync sources. Each source supplies a line pulse stream and a field pulse stream, already separated and synchronous to the system clock. A start pulse from the register side arms a measurement. The meter then waits for a field pulse to open the measurement and for the next field pulse to close it. It reports two 7-bit codes, which the register read path returns unchanged.

The field code is the number of time-base ticks that fit into one field period. A tick comes from a prescaler that advances on qualified clock cycles. Its divide ratio depends on the horizontal rate band in use. The line code is the number of line pulses seen in a window of five ticks that starts at the opening field pulse. Low field codes form a band that means "no field signal". Both codes change together, once per measurement. They hold their values for as long as the register side needs them.

Top module: `sync_rate_meter`

## Requirements
- R1: After reset, `vcode_o` and `hcode_o` are both 0.
- R2: `src_sel` picks the pulse pair. 0 selects index 0 of `hd_in`/`vd_in`, 1 selects index 1, and 2 or 3 select index 2. Pulses on pairs that are not selected have no effect on the codes.
- R3: Field pulses that arrive while no measurement is armed leave both codes unchanged. A measurement is armed only by a one-cycle high on `meas_start`.
- R4: After arming, the first rising edge of the selected field stream opens the measurement and restarts the prescaler. For a closing edge P cycles later, with `base_en` held high, the field code is floor(P / D). D is DIV_LO (default 60) when `hfreq_sel[1]` is 0 and DIV_HI (default 58) when it is 1.
- R5: The prescaler advances only in cycles where `base_en` is high.
- R6: If 128 ticks elapse after the opening edge with no closing edge, both codes become 0.
- R7: If 128 ticks elapse after arming with no opening edge, both codes become 0.
- R8: The line code is the number of rising edges of the selected line stream in the cycles after the opening edge, up to and including the cycle of the fifth tick. The count stops at the closing edge if that comes first, and it saturates at 127.
- R9: When the final field code is below 13, the line code is reported as 0.
- R10: The two codes keep their previous values for the whole measurement. They update together in the cycle after the closing edge.
- R11: A `meas_start` pulse during a measurement discards it and re-arms, so that the next field edge opens a fresh measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_en | input | 1 | Qualifies the cycles counted by the tick prescaler |
| hfreq_sel | input | 2 | Horizontal rate band; bit 1 chooses the tick divide ratio |
| src_sel | input | 2 | Sync source choice |
| hd_in | input | 3 | Line pulse streams, one per source |
| vd_in | input | 3 | Field pulse streams, one per source |
| meas_start | input | 1 | One-cycle pulse that arms a measurement |
| vcode_o | output | 7 | Field period in ticks |
| hcode_o | output | 7 | Line pulses in the five-tick window |

## Verification
The bench drives field periods that are not multiples of the tick length and one that is an exact multiple, which exposes off-by-one errors in the floor count. A period that gives different codes under the two divide ratios shows which ratio is in use. Line streams are driven at several spacings and phases, including a dense stream that saturates the line count and a short field period that falls in the no-signal band. Other runs put pulses on an unselected pair, omit the arming pulse, re-arm in the middle of a measurement, leave out the closing or opening edge, and gate `base_en` at half rate. Each of these runs changes a code only when the corresponding rule is broken.

// File: rtl/rate_meter_pkg.sv
package rate_meter_pkg;

    typedef logic [6:0] rate_code_t;

    localparam int unsigned RATE_CODE_MAX = 127;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } meas_state_e;

endpackage

// File: rtl/rate_tick_gen.sv
module rate_tick_gen #(
    parameter int unsigned DIV_LO = 60,
    parameter int unsigned DIV_HI = 58
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_en,
    input  logic hi_rate,
    input  logic restart,
    output logic tick
);

    localparam int unsigned DIV_MAX = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
    localparam int unsigned PW      = $clog2(DIV_MAX);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } tick_regs_t;

    tick_regs_t    r_q, r_d;
    logic [PW-1:0] div_last;

    always_comb begin
        r_d      = r_q;
        div_last = hi_rate ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
        tick     = base_en && !restart && (r_q.cnt >= div_last);
        if (restart) begin
            r_d.cnt = '0;
        end else if (base_en) begin
            r_d.cnt = (r_q.cnt >= div_last) ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R4: the prescaler never runs past its longest ratio
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < PW'(DIV_MAX));

    // R5: without base_en the prescaler holds its count
    p_hold_when_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_en && !restart) |=> $stable(r_q.cnt));

endmodule

// File: rtl/rate_src_mux.sv
module rate_src_mux #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hd_in,
    input  logic [NSRC-1:0] vd_in,
    input  logic [1:0]      sel,
    output logic            h_rise,
    output logic            v_rise
);

    localparam int unsigned LAST = NSRC - 1;

    typedef struct packed {
        logic h_prev;
        logic v_prev;
    } mux_regs_t;

    mux_regs_t   r_q, r_d;
    int unsigned idx;
    logic        h_cur, v_cur;

    always_comb begin
        idx   = (int'(sel) >= int'(LAST)) ? LAST : int'(sel);
        h_cur = 1'b0;
        v_cur = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (idx == i) begin
                h_cur = hd_in[i];
                v_cur = vd_in[i];
            end
        end
        r_d.h_prev = h_cur;
        r_d.v_prev = v_cur;
        h_rise     = h_cur && !r_q.h_prev;
        v_rise     = v_cur && !r_q.v_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: a field edge is reported for one cycle per rising level
    p_vrise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        v_rise |=> !v_rise);

    // R8: a line edge is reported for one cycle per rising level
    p_hrise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        h_rise |=> !h_rise);

endmodule

// File: rtl/rate_measure_fsm.sv
module rate_measure_fsm
    import rate_meter_pkg::*;
#(
    parameter int unsigned HWIN_TICKS = 5,
    parameter int unsigned TOUT_TICKS = 128,
    parameter int unsigned NOSIG_LIM  = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic       tick,
    input  logic       h_rise,
    input  logic       v_rise,
    output logic       restart,
    output rate_code_t vcode,
    output rate_code_t hcode
);

    localparam int unsigned TW = $clog2(TOUT_TICKS + 1);

    typedef struct packed {
        meas_state_e st;
        logic [TW-1:0] tcnt;
        rate_code_t    hcnt;
        rate_code_t    vcode;
        rate_code_t    hcode;
    } fsm_regs_t;

    fsm_regs_t     r_q, r_d;
    logic [TW-1:0] t_next;
    rate_code_t    h_next;
    rate_code_t    v_final;
    logic          h_open;
    logic          tout_hit;

    always_comb begin
        r_d      = r_q;
        restart  = trig || ((r_q.st == ST_ARM) && v_rise);
        t_next   = r_q.tcnt + TW'(tick);
        tout_hit = tick && (r_q.tcnt == TW'(TOUT_TICKS - 1));
        h_open   = (r_q.tcnt < TW'(HWIN_TICKS));
        h_next   = r_q.hcnt;
        if (h_rise && h_open && (r_q.hcnt != rate_code_t'(RATE_CODE_MAX))) begin
            h_next = r_q.hcnt + 1'b1;
        end
        v_final = (t_next > TW'(RATE_CODE_MAX)) ? rate_code_t'(RATE_CODE_MAX)
                                                : rate_code_t'(t_next);

        if (trig) begin
            r_d.st   = ST_ARM;
            r_d.tcnt = '0;
            r_d.hcnt = '0;
        end else begin
            unique case (r_q.st)
                ST_ARM: begin
                    if (v_rise) begin
                        r_d.st   = ST_RUN;
                        r_d.tcnt = '0;
                        r_d.hcnt = '0;
                    end else if (tout_hit) begin
                        r_d.st    = ST_IDLE;
                        r_d.vcode = '0;
                        r_d.hcode = '0;
                    end else begin
                        r_d.tcnt = t_next;
                    end
                end
                ST_RUN: begin
                    if (v_rise) begin
                        r_d.st    = ST_IDLE;
                        r_d.vcode = v_final;
                        r_d.hcode = (v_final < rate_code_t'(NOSIG_LIM)) ? '0 : h_next;
                    end else if (tout_hit) begin
                        r_d.st    = ST_IDLE;
                        r_d.vcode = '0;
                        r_d.hcode = '0;
                    end else begin
                        r_d.tcnt = t_next;
                        r_d.hcnt = h_next;
                    end
                end
                default: begin
                    r_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign vcode = r_q.vcode;
    assign hcode = r_q.hcode;

    // R6: an open measurement ends before its tick count passes the limit
    p_tcnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> (r_q.tcnt < TW'(TOUT_TICKS)));

    // R11: a start pulse always leaves the meter armed
    p_trig_arms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (r_q.st == ST_ARM));

    // R10: codes only move when a measurement finishes
    p_codes_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) || trig) |=> ($stable(vcode) && $stable(hcode)));

    // R8: the line counter is frozen once the window has closed
    p_hwin_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_RUN) && !h_open && !v_rise && !trig) |=> $stable(r_q.hcnt));

endmodule

// File: rtl/sync_rate_meter.sv
module sync_rate_meter
    import rate_meter_pkg::*;
#(
    parameter int unsigned NSRC       = 3,
    parameter int unsigned DIV_LO     = 60,
    parameter int unsigned DIV_HI     = 58,
    parameter int unsigned HWIN_TICKS = 5,
    parameter int unsigned TOUT_TICKS = 128,
    parameter int unsigned NOSIG_LIM  = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_en,
    input  logic [1:0]      hfreq_sel,
    input  logic [1:0]      src_sel,
    input  logic [NSRC-1:0] hd_in,
    input  logic [NSRC-1:0] vd_in,
    input  logic            meas_start,
    output logic [6:0]      vcode_o,
    output logic [6:0]      hcode_o
);

    logic       tick;
    logic       restart;
    logic       h_rise;
    logic       v_rise;
    rate_code_t vcode;
    rate_code_t hcode;

    rate_src_mux #(
        .NSRC (NSRC)
    ) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .hd_in  (hd_in),
        .vd_in  (vd_in),
        .sel    (src_sel),
        .h_rise (h_rise),
        .v_rise (v_rise)
    );

    rate_tick_gen #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_en (base_en),
        .hi_rate (hfreq_sel[1]),
        .restart (restart),
        .tick    (tick)
    );

    rate_measure_fsm #(
        .HWIN_TICKS (HWIN_TICKS),
        .TOUT_TICKS (TOUT_TICKS),
        .NOSIG_LIM  (NOSIG_LIM)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (meas_start),
        .tick    (tick),
        .h_rise  (h_rise),
        .v_rise  (v_rise),
        .restart (restart),
        .vcode   (vcode),
        .hcode   (hcode)
    );

    assign vcode_o = vcode;
    assign hcode_o = hcode;

    // R9: a field code in the no-signal band never comes with a line count
    p_nosig_band_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode_o < 7'(NOSIG_LIM)) |-> (hcode_o == 7'd0));

    // R1: reset leaves both codes cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> ((vcode_o == 7'd0) && (hcode_o == 7'd0)));

endmodule

// File: tb/sync_rate_meter_tb_top.sv
module sync_rate_meter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DLO        = 60;
    localparam int DHI        = 58;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_en = 1'b1;
    logic [1:0] hfreq_sel = 2'd0;
    logic [1:0] src_sel = 2'd0;
    logic [2:0] hd_in = '0;
    logic [2:0] vd_in = '0;
    logic       meas_start = 1'b0;
    logic [6:0] vcode_o;
    logic [6:0] hcode_o;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sync_rate_meter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_en    (base_en),
        .hfreq_sel  (hfreq_sel),
        .src_sel    (src_sel),
        .hd_in      (hd_in),
        .vd_in      (vd_in),
        .meas_start (meas_start),
        .vcode_o    (vcode_o),
        .hcode_o    (hcode_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errs++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int exp_h(input int fv, input int pv, input int hp, input int hoff,
                                 input int dv, input int y);
        int n = 0;
        int last = fv + 5 * dv;
        if (fv + pv < last) last = fv + pv;
        if (hp > 0) begin
            for (int c = fv + 1; c <= last; c++) begin
                if (c % hp == hoff) n++;
            end
        end
        if (n > 127) n = 127;
        if (y < 13) n = 0;
        return n;
    endfunction

    task automatic arm();
        @(negedge clk);
        meas_start = 1'b1;
    endtask

    task automatic run_frame(input int src, input int fv, input int pv, input int hp,
                             input int hoff, input int early_v, input int retrig_c,
                             input int mid_c, input bit half_en);
        int old_v = int'(vcode_o);
        int old_h = int'(hcode_o);
        for (int c = 0; c < fv + pv + 1; c++) begin
            @(negedge clk);
            meas_start = (c == retrig_c);
            base_en    = half_en ? (c % 2 == 0) : 1'b1;
            vd_in      = '0;
            hd_in      = '0;
            vd_in[src] = (c == fv) || (c == fv + pv) || (c == early_v);
            hd_in[src] = (hp > 0) && (c % hp == hoff);
            if (c == mid_c) begin
                check("R10", "field code held mid-measurement", int'(vcode_o), old_v);
                check("R10", "line code held mid-measurement", int'(hcode_o), old_h);
            end
        end
        @(negedge clk);
        vd_in = '0;
        hd_in = '0;
        meas_start = 1'b0;
        base_en = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic measure(input string req, input int sel, input int src, input int pv,
                           input int hp, input int hoff, input int dv);
        int y = pv / dv;
        src_sel = sel[1:0];
        arm();
        run_frame(src, 10, pv, hp, hoff, -1, -1, -1, 1'b0);
        check(req, "field code", int'(vcode_o), y);
        check(req, "line code", int'(hcode_o), exp_h(10, pv, hp, hoff, dv, y));
    endtask

    task automatic t_reset();
        check("R1", "field code after reset", int'(vcode_o), 0);
        check("R1", "line code after reset", int'(hcode_o), 0);
    endtask

    task automatic t_sources();
        measure("R2/R4/R8 src0", 0, 0, DLO * 20 + 17, 7, 3, DLO);
        measure("R2/R4/R8 src1", 1, 1, DLO * 33 + 5, 9, 4, DLO);
        measure("R2/R4 sel3", 3, 2, DLO * 45 + 2, 5, 1, DLO);
        measure("R2/R4 sel2 exact multiple", 2, 2, DLO * 25, 6, 0, DLO);
    endtask

    task automatic t_hi_rate();
        hfreq_sel = 2'd2;
        measure("R4 high band ratio", 0, 0, 1165, 11, 2, DHI);
        hfreq_sel = 2'd0;
    endtask

    task automatic t_line_sat();
        measure("R8 line saturation", 0, 0, DLO * 30 + 7, 2, 0, DLO);
    endtask

    task automatic t_low_band();
        measure("R9 no-signal band", 0, 0, DLO * 5 + 3, 4, 1, DLO);
    endtask

    task automatic t_no_trigger();
        int ov = int'(vcode_o);
        int oh = int'(hcode_o);
        src_sel = 2'd0;
        run_frame(0, 10, DLO * 30, 3, 0, -1, -1, -1, 1'b0);
        check("R3", "field code without arming", int'(vcode_o), ov);
        check("R3", "line code without arming", int'(hcode_o), oh);
    endtask

    task automatic t_atomic();
        int pv = DLO * 40 + 9;
        src_sel = 2'd1;
        arm();
        run_frame(1, 10, pv, 8, 5, -1, -1, 10 + pv / 2, 1'b0);
        check("R10", "field code after close", int'(vcode_o), 40);
        check("R10", "line code after close", int'(hcode_o), exp_h(10, pv, 8, 5, DLO, 40));
    endtask

    task automatic t_retrigger();
        int pv = DLO * 20 + 17;
        src_sel = 2'd0;
        arm();
        run_frame(0, 400, pv, 7, 2, 5, 300, -1, 1'b0);
        check("R11", "field code after re-arm", int'(vcode_o), 20);
        check("R11", "line code after re-arm", int'(hcode_o), exp_h(400, pv, 7, 2, DLO, 20));
    endtask

    task automatic t_half_enable();
        src_sel = 2'd0;
        arm();
        run_frame(0, 10, 2430, 0, 0, -1, -1, -1, 1'b1);
        check("R5", "field code with half-rate enable", int'(vcode_o), 20);
        check("R5", "line code with no line pulses", int'(hcode_o), 0);
    endtask

    task automatic t_arm_timeout();
        src_sel = 2'd0;
        arm();
        run_frame(2, 10, 1200, 5, 0, -1, -1, -1, 1'b0);
        check("R2", "unselected pair leaves field code", int'(vcode_o), 20);
        repeat (128 * DLO) @(negedge clk);
        check("R7", "field code after arm timeout", int'(vcode_o), 0);
        check("R7", "line code after arm timeout", int'(hcode_o), 0);
    endtask

    task automatic t_run_timeout();
        src_sel = 2'd0;
        arm();
        run_frame(0, 10, 128 * DLO + 300, 6, 1, -1, -1, -1, 1'b0);
        check("R6", "field code after open timeout", int'(vcode_o), 0);
        check("R6", "line code after open timeout", int'(hcode_o), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sources();
        t_hi_rate();
        t_line_sat();
        t_low_band();
        measure("R4 restore", 0, 0, DLO * 20 + 17, 7, 3, DLO);
        t_no_trigger();
        t_atomic();
        t_retrigger();
        t_half_enable();
        t_arm_timeout();
        measure("R4 before open timeout", 1, 1, DLO * 33 + 5, 9, 4, DLO);
        t_run_timeout();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule